// File: doc/BRIEF.md
# DMA Channel Register Front End with Condition Selects

This block is the register-level front end of a single descriptor-driven DMA channel. A 32-bit register bus reaches one channel window. Inside that window the block holds a channel status word, a command pointer pair and three condition select registers. The status word cannot be written directly. Every change arrives through a control port whose written word carries its own per-bit enable mask in the upper half. A device-side strobe can also load the low device-dependent status bits.

Each select register holds a compare mask and a compare value. A select's condition is true when the device status bits, ANDed with the mask, equal the value. The three conditions serve interrupt, branch and wait. Each condition is combined with a matching 2-bit field of the current descriptor, which the descriptor engine supplies. The result is three combinational decisions: take an interrupt, take a branch, stall. Descriptor fetch and data movement sit in other blocks.

Top module: `dmac_chan_regs`

## Requirements
- R1: The asynchronous active-low reset clears the status word, both command pointer registers and all three select registers to zero.
- R2: A bus write to word offset 0x00 changes status bit i to write-data bit i only when write-data bit 16+i is set. All other status bits keep their value.
- R3: Bus reads of offset 0x00 return zero. Reads of unmapped or misaligned offsets (0x1C and above) also return zero.
- R4: Bus writes to the status offset 0x04 and to unmapped offsets change no register.
- R5: The command pointer high (0x08) and command pointer (0x0C) are full 32-bit read/write registers.
- R6: The select registers sit at 0x10 (interrupt), 0x14 (branch) and 0x18 (wait). Each holds a mask in bits 23:16 and a value in bits 7:0. Bits 31:24 and 15:8 read as zero.
- R7: The interrupt, branch and wait condition outputs are high exactly when (select mask AND status[7:0]) equals the select value.
- R8: Each 2-bit descriptor field decodes as 00 never, 01 when the condition is true, 10 when the condition is false, 11 always. It drives do_interrupt, do_branch and do_wait combinationally.
- R9: While dev_we_i is high and no control write occurs, status[7:0] is loaded from dev_status_i and status[15:8] is unchanged.
- R10: When a control write and a device write occur in the same cycle, only the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset within the channel window |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| dev_we_i | input | 1 | Device status load strobe |
| dev_status_i | input | DEV_W | Device-dependent status bits to load |
| desc_intr_i | input | 2 | Descriptor interrupt field |
| desc_branch_i | input | 2 | Descriptor branch field |
| desc_wait_i | input | 2 | Descriptor wait field |
| status_o | output | STAT_W | Current channel status word |
| cmd_ptr_hi_o | output | 32 | Command pointer high register |
| cmd_ptr_o | output | 32 | Command pointer register |
| cond_intr_o | output | 1 | Interrupt select condition |
| cond_branch_o | output | 1 | Branch select condition |
| cond_wait_o | output | 1 | Wait select condition |
| do_interrupt_o | output | 1 | Take-interrupt decision |
| do_branch_o | output | 1 | Take-branch decision |
| do_wait_o | output | 1 | Stall decision |

## Verification
The bench builds the block with its default parameters: an 8-bit window offset, a 16-bit status word and 8 device-dependent bits. With these, every mapped offset and the first unmapped ones can be reached, and the full select byte lanes are exercised. A vector table crosses device status, mask, value and field codes, covering matching, mismatching, all-zero-mask and don't-care cases. Directed tests then cover byte-partial masked writes, the same-cycle write collision and a reset taken mid-run.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_COND = 3;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_PTRH = 3'd2,
    REG_PTR  = 3'd3,
    REG_ISEL = 3'd4,
    REG_BSEL = 3'd5,
    REG_WSEL = 3'd6,
    REG_NONE = 3'd7
  } reg_id_e;

  typedef enum logic [1:0] {
    TAKE_NEVER    = 2'b00,
    TAKE_IF_TRUE  = 2'b01,
    TAKE_IF_FALSE = 2'b10,
    TAKE_ALWAYS   = 2'b11
  } take_e;

  // index 0 interrupt, 1 branch, 2 wait
  localparam reg_id_e SEL_ID [NUM_COND] = '{REG_ISEL, REG_BSEL, REG_WSEL};
  localparam int unsigned SEL_MASK_LSB = 16;
  localparam int unsigned SEL_VAL_LSB  = 0;
endpackage

// File: rtl/dmac_reg_decode.sv
module dmac_reg_decode
  import dmac_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_id_e           id_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  always_comb begin
    id_o = REG_NONE;
    if (addr_i[1:0] == 2'b00 && idx < IDX_W'(REG_NONE))
      id_o = reg_id_e'(idx[2:0]);
  end
endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg #(
  parameter int unsigned STAT_W = 16,
  parameter int unsigned DEV_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_we_i,
  input  logic [2*STAT_W-1:0] ctl_data_i,
  input  logic                dev_we_i,
  input  logic [DEV_W-1:0]    dev_data_i,
  output logic [STAT_W-1:0]   status_o
);
  logic [STAT_W-1:0] status_q, wmask, wval;

  assign wmask = ctl_data_i[2*STAT_W-1:STAT_W];
  assign wval  = ctl_data_i[STAT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (ctl_we_i)  status_q <= (status_q & ~wmask) | (wval & wmask);
    else if (dev_we_i)  status_q[DEV_W-1:0] <= dev_data_i;
  end

  assign status_o = status_q;

  // R2
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ((status_q ^ $past(status_q)) & ~$past(wmask)) == '0);
  // R10
  ctl_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && dev_we_i && wmask == '0) |=> $stable(status_q));
  // R9
  dev_upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_we_i && !ctl_we_i) |=> $stable(status_q[STAT_W-1:DEV_W]));
endmodule

// File: rtl/dmac_cond_unit.sv
module dmac_cond_unit
  import dmac_regs_pkg::*;
#(
  parameter int unsigned DEV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DEV_W-1:0]  mask_i,
  input  logic [DEV_W-1:0]  val_i,
  input  logic [DEV_W-1:0]  dev_bits_i,
  input  logic [1:0]        field_i,
  output logic [WORD_W-1:0] image_o,
  output logic              cond_o,
  output logic              take_o
);
  logic [DEV_W-1:0] mask_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      val_q  <= '0;
    end else if (we_i) begin
      mask_q <= mask_i;
      val_q  <= val_i;
    end
  end

  always_comb begin
    image_o = '0;
    image_o[SEL_MASK_LSB +: DEV_W] = mask_q;
    image_o[SEL_VAL_LSB  +: DEV_W] = val_q;
  end

  assign cond_o = ((dev_bits_i & mask_q) == val_q);
  // bit0 qualifies on true, bit1 on false
  assign take_o = (field_i[0] & cond_o) | (field_i[1] & ~cond_o);

  // R8
  never_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i == TAKE_NEVER) |-> !take_o);
  // R8
  always_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i == TAKE_ALWAYS) |-> take_o);
  // R8
  follow_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i == TAKE_IF_FALSE) |-> (take_o != cond_o));
  // R6
  sel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> image_o[SEL_MASK_LSB +: DEV_W] == $past(mask_i));
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAT_W = 16,
  parameter int unsigned DEV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              dev_we_i,
  input  logic [DEV_W-1:0]  dev_status_i,
  input  logic [1:0]        desc_intr_i,
  input  logic [1:0]        desc_branch_i,
  input  logic [1:0]        desc_wait_i,
  output logic [STAT_W-1:0] status_o,
  output logic [31:0]       cmd_ptr_hi_o,
  output logic [31:0]       cmd_ptr_o,
  output logic              cond_intr_o,
  output logic              cond_branch_o,
  output logic              cond_wait_o,
  output logic              do_interrupt_o,
  output logic              do_branch_o,
  output logic              do_wait_o
);
  localparam int unsigned PAD_W = WORD_W - STAT_W;

  reg_id_e           reg_id;
  logic [31:0]       ptr_hi_q, ptr_q;
  logic [STAT_W-1:0] status;
  logic [1:0]        field [NUM_COND];
  logic [NUM_COND-1:0] cond, take;
  logic [31:0]       sel_img [NUM_COND];

  dmac_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (reg_addr_i),
    .id_o   (reg_id)
  );

  dmac_status_reg #(.STAT_W(STAT_W), .DEV_W(DEV_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (reg_we_i && reg_id == REG_CTRL),
    .ctl_data_i (reg_wdata_i[2*STAT_W-1:0]),
    .dev_we_i   (dev_we_i),
    .dev_data_i (dev_status_i),
    .status_o   (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_hi_q <= '0;
      ptr_q    <= '0;
    end else if (reg_we_i) begin
      if (reg_id == REG_PTRH) ptr_hi_q <= reg_wdata_i;
      if (reg_id == REG_PTR)  ptr_q    <= reg_wdata_i;
    end
  end

  assign field[0] = desc_intr_i;
  assign field[1] = desc_branch_i;
  assign field[2] = desc_wait_i;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_sel
    dmac_cond_unit #(.DEV_W(DEV_W)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (reg_we_i && reg_id == SEL_ID[g]),
      .mask_i     (reg_wdata_i[SEL_MASK_LSB +: DEV_W]),
      .val_i      (reg_wdata_i[SEL_VAL_LSB +: DEV_W]),
      .dev_bits_i (status[DEV_W-1:0]),
      .field_i    (field[g]),
      .image_o    (sel_img[g]),
      .cond_o     (cond[g]),
      .take_o     (take[g])
    );
  end

  always_comb begin
    unique case (reg_id)
      REG_STAT: reg_rdata_o = {{PAD_W{1'b0}}, status};
      REG_PTRH: reg_rdata_o = ptr_hi_q;
      REG_PTR:  reg_rdata_o = ptr_q;
      REG_ISEL: reg_rdata_o = sel_img[0];
      REG_BSEL: reg_rdata_o = sel_img[1];
      REG_WSEL: reg_rdata_o = sel_img[2];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign status_o       = status;
  assign cmd_ptr_hi_o   = ptr_hi_q;
  assign cmd_ptr_o      = ptr_q;
  assign cond_intr_o    = cond[0];
  assign cond_branch_o  = cond[1];
  assign cond_wait_o    = cond[2];
  assign do_interrupt_o = take[0];
  assign do_branch_o    = take[1];
  assign do_wait_o      = take[2];

  // R3
  ctrl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o == '0));
  // R4
  stat_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(4) && !dev_we_i) |=> $stable(status_o));
  // R5
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(12)) |=> (cmd_ptr_o == $past(reg_wdata_i)));
endmodule

// File: tb/dmac_chan_regs_tb_top.sv
module dmac_chan_regs_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dev_we = 1'b0;
  logic [7:0]  dev_data = '0;
  logic [1:0]  f_intr = '0, f_br = '0, f_wait = '0;
  logic [15:0] status;
  logic [31:0] ptr_hi, ptr;
  logic        c_i, c_b, c_w, d_i, d_b, d_w;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_chan_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dev_we_i(dev_we),
    .dev_status_i(dev_data), .desc_intr_i(f_intr), .desc_branch_i(f_br),
    .desc_wait_i(f_wait), .status_o(status), .cmd_ptr_hi_o(ptr_hi),
    .cmd_ptr_o(ptr), .cond_intr_o(c_i), .cond_branch_o(c_b),
    .cond_wait_o(c_w), .do_interrupt_o(d_i), .do_branch_o(d_b),
    .do_wait_o(d_w)
  );

  // {dev status, mask, value, field, exp cond, exp take}
  localparam logic [27:0] VEC [9] = '{
    {8'hA5, 8'hFF, 8'hA5, 2'b01, 1'b1, 1'b1},
    {8'hA5, 8'hFF, 8'hA4, 2'b01, 1'b0, 1'b0},
    {8'hA5, 8'h0F, 8'h05, 2'b10, 1'b1, 1'b0},
    {8'h3C, 8'hF0, 8'h20, 2'b10, 1'b0, 1'b1},
    {8'h00, 8'h00, 8'h00, 2'b00, 1'b1, 1'b0},
    {8'h81, 8'h80, 8'h80, 2'b11, 1'b1, 1'b1},
    {8'h01, 8'h80, 8'h80, 2'b11, 1'b0, 1'b1},
    {8'hFF, 8'h00, 8'h01, 2'b11, 1'b0, 1'b1},
    {8'h42, 8'h42, 8'h42, 2'b00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic dw, input logic [7:0] dd);
    @(negedge clk);
    we = w; addr = a; wdata = d; dev_we = dw; dev_data = dd;
    @(negedge clk);
    we = 1'b0; dev_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "status", {16'h0, status}, 32'h0);
    chk("R1", "ptr_hi", ptr_hi, 32'h0);
    chk("R1", "ptr", ptr, 32'h0);
    rd(8'h10, r); chk("R1", "isel", r, 32'h0);
    rd(8'h18, r); chk("R1", "wsel", r, 32'h0);

    // R7 R8 R9 table
    foreach (VEC[i]) begin
      logic [27:0] v;
      v = VEC[i];
      for (int s = 0; s < 3; s++)
        cyc(1'b1, 8'h10 + 8'(4*s), {8'h0, v[19:12], 8'h0, v[11:4]}, 1'b0, 8'h0);
      f_intr = v[3:2]; f_br = v[3:2]; f_wait = v[3:2];
      cyc(1'b0, 8'h20, 32'h0, 1'b1, v[27:20]);
      #1;
      chk("R9", "dev load", {24'h0, status[7:0]}, {24'h0, v[27:20]});
      chk("R7", "conds", {29'h0, c_i, c_b, c_w}, {29'h0, {3{v[1]}}});
      chk("R8", "takes", {29'h0, d_i, d_b, d_w}, {29'h0, {3{v[0]}}});
    end

    // R2 masked control writes
    cyc(1'b1, 8'h00, 32'hFFFF_0000, 1'b0, 8'h0);
    chk("R2", "clear all", {16'h0, status}, 32'h0);
    cyc(1'b1, 8'h00, 32'h00FF_1234, 1'b0, 8'h0);
    chk("R2", "low byte", {16'h0, status}, 32'h0034);
    cyc(1'b1, 8'h00, 32'hFF00_AB00, 1'b0, 8'h0);
    chk("R2", "high byte", {16'h0, status}, 32'hAB34);
    cyc(1'b1, 8'h00, 32'h0001_FFFF, 1'b0, 8'h0);
    rd(8'h04, r); chk("R2", "single bit", r, 32'hAB35);

    // R3 reads of control and unmapped
    rd(8'h00, r); chk("R3", "ctrl read", r, 32'h0);
    rd(8'h1C, r); chk("R3", "0x1C read", r, 32'h0);
    rd(8'h0D, r); chk("R3", "misaligned read", r, 32'h0);

    // R5 pointers
    cyc(1'b1, 8'h0C, 32'hDEAD_BEEF, 1'b0, 8'h0);
    cyc(1'b1, 8'h08, 32'h1234_5678, 1'b0, 8'h0);
    rd(8'h0C, r); chk("R5", "ptr", r, 32'hDEAD_BEEF);
    rd(8'h08, r); chk("R5", "ptr_hi", r, 32'h1234_5678);

    // R4 ignored writes
    cyc(1'b1, 8'h04, 32'hFFFF_FFFF, 1'b0, 8'h0);
    rd(8'h04, r); chk("R4", "status write", r, 32'hAB35);
    cyc(1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0, 8'h0);
    cyc(1'b1, 8'h1C, 32'hFFFF_FFFF, 1'b0, 8'h0);
    chk("R4", "ptr after unmapped", ptr, 32'hDEAD_BEEF);
    chk("R4", "ptr_hi after unmapped", ptr_hi, 32'h1234_5678);
    chk("R4", "status after unmapped", {16'h0, status}, 32'hAB35);

    // R6 select layout
    cyc(1'b1, 8'h14, 32'hFFFF_FFFF, 1'b0, 8'h0);
    rd(8'h14, r); chk("R6", "bsel image", r, 32'h00FF_00FF);
    cyc(1'b1, 8'h10, 32'h12C3_3481, 1'b0, 8'h0);
    rd(8'h10, r); chk("R6", "isel image", r, 32'h00C3_0081);

    // R9 device load keeps upper
    cyc(1'b0, 8'h00, 32'h0, 1'b1, 8'h5A);
    chk("R9", "dev write", {16'h0, status}, 32'hAB5A);

    // R10 collision
    cyc(1'b1, 8'h00, 32'h00F0_0060, 1'b1, 8'h0F);
    chk("R10", "ctrl wins", {16'h0, status}, 32'hAB6A);
    cyc(1'b1, 8'h00, 32'h0000_0000, 1'b1, 8'h00);
    chk("R10", "empty mask wins", {16'h0, status}, 32'hAB6A);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1", "status mid reset", {16'h0, status}, 32'h0);
    chk("R1", "ptr mid reset", ptr, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h14, r); chk("R1", "bsel mid reset", r, 32'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule